// File: doc/BRIEF.md
# Descriptor Ring Controller with Control/Status Register

This block runs a circular queue of 64-byte command descriptors for a cipher engine. Software sets up the ring's lower bound, upper bound, consumer pointer and producer pointer through a small register port. It then turns the controller on through a control/status word and submits work by moving the producer pointer forward one descriptor (0x40 bytes) at a time. The block holds only the low 48 bits of each pointer, since they carry physical addresses.

While enabled and the consumer pointer differs from the producer pointer, the controller reads the useful doublewords of the descriptor at the consumer pointer over a one-request-at-a-time memory read port. It decodes the header word and presents the whole job to the engine with a valid/done handshake. It then moves the consumer pointer forward, wrapping at the upper bound, and pulses an event output once per completed job. Illegal pointer writes raise a sticky protocol-error flag that halts the queue. Clearing the enable bit while a job is in flight lets the engine finish, then stops with the terminated flag set and the job left on the queue.

Top module: `desc_ring_ctrl`

## Requirements
- R1: Register addresses are 0 = control/status, 1 = ring lower bound, 2 = ring upper bound, 3 = consumer pointer, 4 = producer pointer. Each pointer keeps bits 47:0 of the written value, reads bits 63:48 as zero, and reads back combinationally on `reg_rdata`.
- R2: The control/status word has bit 0 = enable, bit 1 = terminated, bit 2 = busy and bit 3 = protocol error. Bits 63:4 read as zero, and every register reads zero after reset.
- R3: A control/status write with bit 0 = 1 sets enable and clears terminated and protocol error. A write with bit 0 = 0 clears enable and leaves the other flags as they are.
- R4: A consumer or producer pointer write whose 48-bit value is not a multiple of 64 sets protocol error. So does one that lies outside lower bound <= value < upper bound. The value is still stored, the flag holds until an enabling control write, and no descriptor is started while it is set.
- R5: Busy reads 1 while a descriptor is in flight, and also while enable = 1, protocol error = 0 and consumer != producer. It reads 0 once the queue is drained and idle.
- R6: For each descriptor the block reads the doublewords at byte offsets 0x00, 0x08, 0x28, 0x30 and 0x38 from the consumer pointer, in that order. It never reads offsets 0x10 to 0x20. `mem_req` and `mem_addr` hold steady until `mem_rvalid`.
- R7: The engine sees the following header fields: opcode = header[63:56], encrypt = header[55], start-of-block = header[54], end-of-block = header[53], cipher type = header[31:24] and byte length = header[23:0] + 1. It also sees source = word 0x08, key = word 0x28, IV = word 0x30 and destination = word 0x38, each truncated to 48 bits. All of these hold steady while `eng_valid` waits for `eng_done`.
- R8: `eng_valid` stays high until `eng_done`. After done with enable still set, the consumer pointer advances by 0x40, or goes back to the lower bound when the sum reaches the upper bound, and `event_pulse` is high for exactly one cycle.
- R9: If enable is clear when `eng_done` arrives, the handshake still completes. Terminated is set, the consumer pointer is not advanced and no event pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 48 | Doubleword address being read |
| mem_rvalid | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 64 | Read data |
| eng_valid | output | 1 | Job offered to the engine |
| eng_op | output | 8 | Opcode |
| eng_encrypt | output | 1 | Encrypt flag |
| eng_sob | output | 1 | Start-of-block flag |
| eng_eob | output | 1 | End-of-block flag |
| eng_ctype | output | 8 | Cipher type |
| eng_len | output | 25 | Job length in bytes |
| eng_src | output | 48 | Source address |
| eng_key | output | 48 | Key address |
| eng_iv | output | 48 | IV address |
| eng_dst | output | 48 | Destination address |
| eng_done | input | 1 | Engine completion pulse |
| event_pulse | output | 1 | One pulse per completed job |

## Verification
The assertions assume the memory answers each request with exactly one `mem_rvalid` pulse and the engine gives one `eng_done` pulse per offered job. They also assume software rewrites the consumer pointer only while the queue is idle and never submits more than the ring holds minus one. The bench keeps to all of this by construction: its memory and engine stubs answer with random delays of 0 to 3 cycles, and the engine can be held to create a long in-flight window. Random batches of one to three descriptors are submitted and drained before the next batch, and they cross the ring's wrap point several times.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  // register map
  localparam logic [2:0] RA_CSR   = 3'd0;
  localparam logic [2:0] RA_FIRST = 3'd1;
  localparam logic [2:0] RA_LAST  = 3'd2;
  localparam logic [2:0] RA_HEAD  = 3'd3;
  localparam logic [2:0] RA_TAIL  = 3'd4;

  // control/status bit positions
  localparam int CSR_EN   = 0;
  localparam int CSR_TERM = 1;
  localparam int CSR_BUSY = 2;
  localparam int CSR_PERR = 3;

  // doubleword slots inside a descriptor that carry information
  localparam int W_HDR = 0;
  localparam int W_SRC = 1;
  localparam int W_KEY = 5;
  localparam int W_IV  = 6;
  localparam int W_DST = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_ADV   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
  import desc_ring_pkg::*;
#(
  parameter int AW         = 48,
  parameter int DW         = 64,
  parameter int DESC_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          adv_head,
  input  logic          set_term,
  input  logic          busy,
  output logic [AW-1:0] first_ptr,
  output logic [AW-1:0] last_ptr,
  output logic [AW-1:0] head_ptr,
  output logic [AW-1:0] tail_ptr,
  output logic          en,
  output logic          perr
);
  localparam int OFF_W = $clog2(DESC_BYTES);

  logic [AW-1:0] first_q, last_q, head_q, tail_q;
  logic [AW-1:0] first_d, last_d, head_d, tail_d;
  logic          en_q, term_q, perr_q;
  logic          en_d, term_d, perr_d;
  logic          ld_first, ld_last, ld_head, ld_tail, ld_csr;
  logic [AW-1:0] wr_val, head_inc, head_wrap;
  logic          wr_bad, csr_arm;

  assign wr_val    = reg_wdata[AW-1:0];
  assign wr_bad    = (wr_val[OFF_W-1:0] != '0) || (wr_val < first_q) || (wr_val >= last_q);
  assign head_inc  = head_q + AW'(DESC_BYTES);
  assign head_wrap = (head_inc >= last_q) ? first_q : head_inc;
  assign csr_arm   = reg_wr && (reg_addr == RA_CSR) && reg_wdata[CSR_EN];

  // next-state
  always_comb begin
    ld_first = reg_wr && (reg_addr == RA_FIRST);
    ld_last  = reg_wr && (reg_addr == RA_LAST);
    ld_tail  = reg_wr && (reg_addr == RA_TAIL);
    ld_head  = (reg_wr && (reg_addr == RA_HEAD)) || adv_head;
    ld_csr   = (reg_wr && (reg_addr == RA_CSR)) || set_term ||
               (reg_wr && ((reg_addr == RA_HEAD) || (reg_addr == RA_TAIL)) && wr_bad);

    first_d = wr_val;
    last_d  = wr_val;
    tail_d  = wr_val;
    head_d  = (reg_wr && (reg_addr == RA_HEAD)) ? wr_val : head_wrap;

    en_d   = en_q;
    term_d = term_q;
    perr_d = perr_q;
    if (reg_wr && (reg_addr == RA_CSR)) en_d = reg_wdata[CSR_EN];
    if (set_term) term_d = 1'b1;
    if (reg_wr && ((reg_addr == RA_HEAD) || (reg_addr == RA_TAIL)) && wr_bad) perr_d = 1'b1;
    if (csr_arm) begin
      term_d = 1'b0;
      perr_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      en_q    <= 1'b0;
      term_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      if (ld_first) first_q <= first_d;
      if (ld_last)  last_q  <= last_d;
      if (ld_head)  head_q  <= head_d;
      if (ld_tail)  tail_q  <= tail_d;
      if (ld_csr) begin
        en_q   <= en_d;
        term_q <= term_d;
        perr_q <= perr_d;
      end
    end
  end

  // readback
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CSR: begin
        reg_rdata[CSR_EN]   = en_q;
        reg_rdata[CSR_TERM] = term_q;
        reg_rdata[CSR_BUSY] = busy;
        reg_rdata[CSR_PERR] = perr_q;
      end
      RA_FIRST: reg_rdata = DW'(first_q);
      RA_LAST:  reg_rdata = DW'(last_q);
      RA_HEAD:  reg_rdata = DW'(head_q);
      RA_TAIL:  reg_rdata = DW'(tail_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign first_ptr = first_q;
  assign last_ptr  = last_q;
  assign head_ptr  = head_q;
  assign tail_ptr  = tail_q;
  assign en        = en_q;
  assign perr      = perr_q;

  // R4: error flag stays until an enabling control write
  assert_perr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q && !csr_arm |=> perr_q);

  // R4: an illegal pointer write raises the error flag
  assert_bad_ptr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == RA_TAIL) && (reg_wdata[OFF_W-1:0] != '0) |=> perr_q);

  // R9: a terminated job never advances the consumer pointer
  assert_term_no_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_term |-> !adv_head);

  // R3: enabling write clears terminated
  assert_arm_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_arm |=> !term_q && en_q);
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
  import desc_ring_pkg::*;
#(
  parameter int AW         = 48,
  parameter int DESC_BYTES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               perr,
  input  logic [AW-1:0]      head_ptr,
  input  logic [AW-1:0]      tail_ptr,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_rvalid,
  output logic               cap_en,
  output logic [$clog2(DESC_BYTES/8)-1:0] cap_idx,
  output logic               eng_valid,
  input  logic               eng_done,
  output logic               adv_head,
  output logic               set_term,
  output logic               busy,
  output logic               event_pulse
);
  localparam int WORDS = DESC_BYTES / 8;
  localparam int WI_W  = $clog2(WORDS);

  seq_state_t      state_q, state_d;
  logic [WI_W-1:0] idx_q, idx_d;
  logic            start;

  assign start = en && !perr && (head_ptr != tail_ptr);

  // next-state
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    set_term = 1'b0;
    adv_head = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_FETCH;
          idx_d   = WI_W'(W_HDR);
        end
      end
      ST_FETCH: begin
        if (mem_rvalid) begin
          if (idx_q == WI_W'(W_DST))      state_d = ST_EXEC;
          else if (idx_q == WI_W'(W_SRC)) idx_d   = WI_W'(W_KEY);
          else                            idx_d   = idx_q + 1'b1;
        end
      end
      ST_EXEC: begin
        if (eng_done) begin
          if (en) state_d = ST_ADV;
          else begin
            state_d  = ST_IDLE;
            set_term = 1'b1;
          end
        end
      end
      ST_ADV: begin
        adv_head = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign mem_req     = (state_q == ST_FETCH);
  assign mem_addr    = head_ptr + AW'({idx_q, 3'b000});
  assign cap_en      = mem_req && mem_rvalid;
  assign cap_idx     = idx_q;
  assign eng_valid   = (state_q == ST_EXEC);
  assign event_pulse = adv_head;
  assign busy        = (state_q != ST_IDLE) || start;

  // R6: request and address hold until the data returns
  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R6: unused descriptor slots are never read
  assert_no_unused_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (idx_q < WI_W'(2)) || (idx_q > WI_W'(4)));

  // R8: offer held until done
  assert_valid_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_done |=> eng_valid);

  // R8: event is a single-cycle pulse
  assert_event_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |=> !event_pulse);

  // R5: a job on offer always reads as busy
  assert_busy_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> busy);
endmodule

// File: rtl/desc_ring_decode.sv
module desc_ring_decode
  import desc_ring_pkg::*;
#(
  parameter int AW    = 48,
  parameter int DW    = 64,
  parameter int LEN_W = 24,
  parameter int WI_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [WI_W-1:0] cap_idx,
  input  logic [DW-1:0]   cap_data,
  output logic [7:0]      op,
  output logic            encrypt,
  output logic            sob,
  output logic            eob,
  output logic [7:0]      ctype,
  output logic [LEN_W:0]  len_bytes,
  output logic [AW-1:0]   src,
  output logic [AW-1:0]   key,
  output logic [AW-1:0]   iv,
  output logic [AW-1:0]   dst
);
  logic [DW-1:0] hdr_q;
  logic [AW-1:0] src_q, key_q, iv_q, dst_q;
  logic          ld_hdr, ld_src, ld_key, ld_iv, ld_dst;

  always_comb begin
    ld_hdr = cap_en && (cap_idx == WI_W'(W_HDR));
    ld_src = cap_en && (cap_idx == WI_W'(W_SRC));
    ld_key = cap_en && (cap_idx == WI_W'(W_KEY));
    ld_iv  = cap_en && (cap_idx == WI_W'(W_IV));
    ld_dst = cap_en && (cap_idx == WI_W'(W_DST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      src_q <= '0;
      key_q <= '0;
      iv_q  <= '0;
      dst_q <= '0;
    end else begin
      if (ld_hdr) hdr_q <= cap_data;
      if (ld_src) src_q <= cap_data[AW-1:0];
      if (ld_key) key_q <= cap_data[AW-1:0];
      if (ld_iv)  iv_q  <= cap_data[AW-1:0];
      if (ld_dst) dst_q <= cap_data[AW-1:0];
    end
  end

  assign op        = hdr_q[63:56];
  assign encrypt   = hdr_q[55];
  assign sob       = hdr_q[54];
  assign eob       = hdr_q[53];
  assign ctype     = hdr_q[31:24];
  assign len_bytes = {1'b0, hdr_q[LEN_W-1:0]} + 1'b1;
  assign src       = src_q;
  assign key       = key_q;
  assign iv        = iv_q;
  assign dst       = dst_q;
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int AW         = 48,
  parameter int DW         = 64,
  parameter int DESC_BYTES = 64,
  parameter int LEN_W      = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            eng_valid,
  output logic [7:0]      eng_op,
  output logic            eng_encrypt,
  output logic            eng_sob,
  output logic            eng_eob,
  output logic [7:0]      eng_ctype,
  output logic [LEN_W:0]  eng_len,
  output logic [AW-1:0]   eng_src,
  output logic [AW-1:0]   eng_key,
  output logic [AW-1:0]   eng_iv,
  output logic [AW-1:0]   eng_dst,
  input  logic            eng_done,
  output logic            event_pulse
);
  localparam int WI_W = $clog2(DESC_BYTES / 8);

  logic [AW-1:0]   first_ptr, last_ptr, head_ptr, tail_ptr;
  logic            en, perr, busy, adv_head, set_term, cap_en;
  logic [WI_W-1:0] cap_idx;

  desc_ring_regs #(.AW(AW), .DW(DW), .DESC_BYTES(DESC_BYTES)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .adv_head, .set_term, .busy,
    .first_ptr, .last_ptr, .head_ptr, .tail_ptr, .en, .perr
  );

  desc_ring_seq #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_seq (
    .clk, .rst_n, .en, .perr, .head_ptr, .tail_ptr,
    .mem_req, .mem_addr, .mem_rvalid, .cap_en, .cap_idx,
    .eng_valid, .eng_done, .adv_head, .set_term, .busy, .event_pulse
  );

  desc_ring_decode #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .WI_W(WI_W)) u_dec (
    .clk, .rst_n, .cap_en, .cap_idx, .cap_data(mem_rdata),
    .op(eng_op), .encrypt(eng_encrypt), .sob(eng_sob), .eob(eng_eob),
    .ctype(eng_ctype), .len_bytes(eng_len),
    .src(eng_src), .key(eng_key), .iv(eng_iv), .dst(eng_dst)
  );

  // R7: job fields hold while the offer waits
  assert_fields_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_done |=> $stable(eng_op) && $stable(eng_len) &&
                               $stable(eng_src) && $stable(eng_dst));

  // R1: unused upper bits of a pointer readback are zero
  assert_ptr_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != RA_CSR) |-> (reg_rdata[DW-1:AW] == '0));
endmodule

// File: tb/desc_ring_ctrl_tb.sv
module desc_ring_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] BASE  = 48'h0012_3456_8000;
  localparam logic [47:0] LIMIT = BASE + 48'h200;   // 8 slots

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_rvalid;
  logic [47:0] mem_addr;
  logic [63:0] mem_rdata;
  logic        eng_valid, eng_encrypt, eng_sob, eng_eob, eng_done, event_pulse;
  logic [7:0]  eng_op, eng_ctype;
  logic [24:0] eng_len;
  logic [47:0] eng_src, eng_key, eng_iv, eng_dst;

  desc_ring_ctrl u_dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .eng_valid, .eng_op, .eng_encrypt, .eng_sob, .eng_eob, .eng_ctype, .eng_len,
    .eng_src, .eng_key, .eng_iv, .eng_dst, .eng_done, .event_pulse
  );

  int n_checks = 0;
  int n_fail = 0;
  int ev_cnt = 0;
  int fetch_pos = 0;
  int mdly = 0;
  int edly = 0;
  logic eng_hold = 1'b0;
  logic [47:0] exp_head = BASE;
  logic [47:0] tail_m = BASE;
  logic [63:0] mem [0:63];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] next_ptr(input logic [47:0] p);
    logic [47:0] n;
    n = p + 48'h40;
    return (n >= LIMIT) ? BASE : n;
  endfunction

  function automatic int slot_of(input logic [47:0] p);
    return int'((p - BASE) >> 6);
  endfunction

  function automatic int exp_off(input int pos);
    case (pos)
      0: return 0;
      1: return 1;
      2: return 5;
      3: return 6;
      default: return 7;
    endcase
  endfunction

  // memory stub: one response per request, random latency
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req && !mem_rvalid) begin
      if (mdly == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[int'((mem_addr - BASE) >> 3) & 63];
        chk(int'(mem_addr[5:3]) == exp_off(fetch_pos), "R6 fetch order",
            64'(mem_addr[5:3]), 64'(exp_off(fetch_pos)));
        fetch_pos = (fetch_pos == 4) ? 0 : fetch_pos + 1;
        mdly <= $urandom % 4;
      end else mdly <= mdly - 1;
    end
  end

  // engine stub: checks the offered job against the descriptor in memory
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (rst_n && eng_valid && !eng_done && !eng_hold) begin
      if (edly == 0) begin
        logic [63:0] w0;
        int s;
        s  = slot_of(exp_head);
        w0 = mem[s*8];
        chk(eng_op == w0[63:56], "R7 opcode", 64'(eng_op), 64'(w0[63:56]));
        chk({eng_encrypt, eng_sob, eng_eob} == w0[55:53], "R7 flags",
            64'({eng_encrypt, eng_sob, eng_eob}), 64'(w0[55:53]));
        chk(eng_ctype == w0[31:24], "R7 cipher type", 64'(eng_ctype), 64'(w0[31:24]));
        chk(eng_len == 25'(w0[23:0]) + 25'd1, "R7 length", 64'(eng_len), 64'(w0[23:0]) + 64'd1);
        chk({eng_src, eng_key, eng_iv, eng_dst} ==
            {mem[s*8+1][47:0], mem[s*8+5][47:0], mem[s*8+6][47:0], mem[s*8+7][47:0]},
            "R7 addresses", 64'(eng_dst), 64'(mem[s*8+7][47:0]));
        eng_done <= 1'b1;
        edly <= $urandom % 4;
      end else edly <= edly - 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n && event_pulse) begin
      ev_cnt++;
      exp_head <= next_ptr(exp_head);
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic submit(input logic [63:0] w0);
    int s;
    s = slot_of(tail_m);
    mem[s*8]   = w0;
    mem[s*8+1] = {$urandom, $urandom};
    for (int k = 2; k < 5; k++) mem[s*8+k] = 64'hAAAA_AAAA_AAAA_AAAA;
    mem[s*8+5] = {$urandom, $urandom};
    mem[s*8+6] = {$urandom, $urandom};
    mem[s*8+7] = {$urandom, $urandom};
    tail_m = next_ptr(tail_m);
    reg_write(3'd4, {16'h0, tail_m});
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_read(3'd0, v);
      if (!v[2]) break;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int ev0;
    void'($urandom(32'h5EED_0042));
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), v);
      chk(v == 64'h0, "R2 reset readback", v, 64'h0);
    end
    chk(!eng_valid && !mem_req, "R2 reset outputs idle", 64'({eng_valid, mem_req}), 64'h0);

    // pointer truncation
    reg_write(3'd1, {16'hFFFF, BASE});
    reg_read(3'd1, v);
    chk(v == {16'h0, BASE}, "R1 lower bound masked", v, {16'h0, BASE});
    reg_write(3'd2, {16'hBEEF, LIMIT});
    reg_read(3'd2, v);
    chk(v == {16'h0, LIMIT}, "R1 upper bound masked", v, {16'h0, LIMIT});
    reg_write(3'd3, {16'h1234, BASE});
    reg_read(3'd3, v);
    chk(v == {16'h0, BASE}, "R1 consumer masked", v, {16'h0, BASE});
    reg_read(3'd0, v);
    chk(v == 64'h0, "R4 legal write leaves error clear", v, 64'h0);

    // misaligned producer
    reg_write(3'd4, {16'h0, BASE + 48'h10});
    reg_read(3'd0, v);
    chk(v == 64'h8, "R4 misaligned sets error", v, 64'h8);
    reg_read(3'd4, v);
    chk(v == {16'h0, BASE + 48'h10}, "R4 value still stored", v, {16'h0, BASE + 48'h10});
    reg_write(3'd4, {16'h0, BASE});
    reg_write(3'd0, 64'h0);
    reg_read(3'd0, v);
    chk(v == 64'h8, "R3 disabling write keeps error", v, 64'h8);
    reg_write(3'd0, 64'h1);
    reg_read(3'd0, v);
    chk(v == 64'h1, "R3 enabling write clears error", v, 64'h1);

    // out of range producer halts processing
    reg_write(3'd4, {16'h0, LIMIT});
    repeat (20) @(negedge clk);
    chk(!mem_req, "R4 no fetch while error", 64'(mem_req), 64'h0);
    reg_read(3'd0, v);
    chk(v == 64'h9, "R4 out of range sets error, not busy", v, 64'h9);
    reg_write(3'd4, {16'h0, BASE});
    reg_write(3'd0, 64'h1);

    // directed job
    submit(64'h40E0_0000_0900_0017);
    reg_read(3'd0, v);
    chk(v[2] == 1'b1, "R5 busy after submit", 64'(v[2]), 64'h1);
    wait_idle();
    chk(ev_cnt == 1, "R8 one event", 64'(ev_cnt), 64'h1);
    reg_read(3'd3, v);
    chk(v == {16'h0, BASE + 48'h40}, "R8 consumer advanced", v, {16'h0, BASE + 48'h40});
    reg_read(3'd0, v);
    chk(v == 64'h1, "R5 idle after drain", v, 64'h1);

    // random batches, crossing the wrap point
    for (int b = 0; b < 20; b++) begin
      int k;
      k = 1 + ($urandom % 3);
      ev0 = ev_cnt;
      for (int j = 0; j < k; j++) submit({$urandom, $urandom});
      wait_idle();
      chk(ev_cnt == ev0 + k, "R8 events equal submissions", 64'(ev_cnt), 64'(ev0 + k));
      reg_read(3'd3, v);
      chk(v == {16'h0, tail_m}, "R8 consumer reaches producer with wrap", v, {16'h0, tail_m});
    end

    // termination
    eng_hold = 1'b1;
    ev0 = ev_cnt;
    submit(64'h11A0_0000_0300_003F);
    for (int i = 0; i < 200 && !eng_valid; i++) @(negedge clk);
    reg_write(3'd0, 64'h0);
    repeat (5) @(negedge clk);
    chk(eng_valid, "R9 handshake continues after disable", 64'(eng_valid), 64'h1);
    eng_hold = 1'b0;
    for (int i = 0; i < 200 && eng_valid; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    reg_read(3'd0, v);
    chk(v == 64'h2, "R9 terminated set", v, 64'h2);
    reg_read(3'd3, v);
    chk(v == {16'h0, exp_head}, "R9 consumer not advanced", v, {16'h0, exp_head});
    chk(ev_cnt == ev0, "R9 no event", 64'(ev_cnt), 64'(ev0));
    reg_write(3'd0, 64'h1);
    reg_read(3'd0, v);
    chk(v[1:0] == 2'b01, "R3 re-enable clears terminated", 64'(v[1:0]), 64'h1);
    wait_idle();
    chk(ev_cnt == ev0 + 1, "R8 resumed job completes", 64'(ev_cnt), 64'(ev0 + 1));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule